// File: doc/BRIEF.md
# Receive Descriptor Ring Index Controller

This block manages, on the device side, a circular ring of receive buffer descriptors that it shares with a host. The host programs one configuration word and advances a write index. The configuration word sets the ring size exponent, the buffer size code, the run mode, the interrupt target and a close timeout. The block offers the next free descriptor index to an internal fill engine. It keeps that buffer open while the engine fills it, and then closes it. A buffer closes either when the engine reports it full or when the timeout runs out. Each close moves the closed index into the status index, pulses an update strobe, and can raise a host interrupt.

The ring counts as full when the next index to hand out equals the host's write index, so the host can have at most ring size minus one buffers outstanding. The host write index is used only in steps of eight. The block opens one buffer at a time. Descriptor fetch and data movement lie outside the block, and the fill engine is seen only through a grant, data, end-of-frame and done handshake. The timeout counts in units of `TICK_CYC` clock cycles, each unit standing for 32 µs.

Top module: `rxring_ctrl`

## Requirements
- R1: After reset, no descriptor is offered, the channel reports idle, the status index is 0, and neither the update strobe nor the interrupt is active.
- R2: The ring holds 2^N entries, with N taken from the 4-bit size field and clamped to the range 5..12. An N of 3 gives 32 entries. The index handed out wraps from 2^N-1 to 0.
- R3: A host write index is rounded down to a multiple of 8 and reduced modulo the ring size before use. For example, 0x03B in a 32-entry ring acts as 24.
- R4: No descriptor is offered while the next index to hand out equals the effective write index. With a write index of 8 after reset, exactly the indices 0..7 are handed out.
- R5: In run mode (mode code 2'b10), a descriptor is offered when the ring has room and no buffer is open. A grant opens the buffer, and no further descriptor is offered until that buffer closes.
- R6: A done indication closes the open buffer. In the cycle after the close edge, the update strobe is high for exactly one cycle and the status index equals the closed buffer's index.
- R7: The host interrupt pulses together with the update strobe only when the interrupt target code is 2'b01. With code 2'b00 it stays low.
- R8: The timeout closes an open buffer timeout×TICK_CYC cycles after the edge that samples its first data beat. The timer does not run before the first data beat, and a timeout of 0 disables it.
- R9: A done indication in the same cycle as timeout expiry produces exactly one close: one update pulse, one interrupt and one advance of the index.
- R10: In pause-at-end-of-frame mode (code 2'b01), descriptors are offered until an end-of-frame is seen and none afterwards, until the configuration is rewritten. In off mode (code 2'b00), none are offered.
- R11: The channel reports idle exactly when the mode is off and no buffer is open. A buffer left open when the mode is switched off keeps the channel busy until it closes.
- R12: The buffer size output is 4, 8, 12 or 16 kB for the codes 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Run mode: 00 off, 01 pause at end of frame, 10 run |
| cfg_log_size | input | 4 | Ring size exponent |
| cfg_buf_code | input | 2 | Buffer size code |
| cfg_irq_dest | input | 2 | Interrupt target: 00 none, 01 host |
| cfg_timeout | input | TMO_W | Close timeout in ticks, 0 disables |
| wptr_we | input | 1 | Host write index strobe |
| wptr_val | input | IDX_W | Host write index |
| desc_req | output | 1 | Descriptor offered to the fill engine |
| desc_idx | output | IDX_W | Index of the offered descriptor |
| desc_gnt | input | 1 | Fill engine takes the offered descriptor |
| fill_kb | output | 5 | Buffer size in kB |
| data_in | input | 1 | Data beat entering the open buffer |
| frame_end | input | 1 | End of the current frame |
| buf_done | input | 1 | Fill engine closes the open buffer |
| stat_upd | output | 1 | Status index update pulse |
| stat_idx | output | IDX_W | Index of the last filled descriptor |
| host_irq | output | 1 | Host interrupt pulse |
| chan_idle | output | 1 | Channel stopped with no buffer open |

## Verification
Two functions can coincide: the fill engine's done indication, and expiry of the close timer, in the same cycle. The bench provokes this by opening a buffer, sending one data beat, and counting edges until the cycle just before expiry is due. It then asserts done in that very cycle. The result is judged correct only if exactly one update pulse and one interrupt appear, the status index names the buffer once, and the next offered index has advanced by exactly one.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_EOF = 2'b01,
    MODE_RUN = 2'b10,
    MODE_RSV = 2'b11
  } rx_mode_e;

  localparam logic [1:0] DEST_HOST = 2'b01;
endpackage

// File: rtl/rxring_cfg.sv
module rxring_cfg
  import rxring_pkg::*;
#(
  parameter int IDX_W   = 12,
  parameter int LOG_MIN = 5,
  parameter int LOG_MAX = 12,
  parameter int TMO_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [3:0]       cfg_log_size,
  input  logic [1:0]       cfg_buf_code,
  input  logic [1:0]       cfg_irq_dest,
  input  logic [TMO_W-1:0] cfg_timeout,
  output rx_mode_e         mode,
  output logic [IDX_W-1:0] ring_mask,
  output logic [4:0]       fill_kb,
  output logic [1:0]       irq_dest,
  output logic [TMO_W-1:0] timeout
);
  localparam logic [3:0] LMIN = 4'(LOG_MIN);
  localparam logic [3:0] LMAX = 4'(LOG_MAX);

  rx_mode_e         mode_q, mode_d;
  logic [3:0]       log_q, log_d, log_eff;
  logic [1:0]       code_q, code_d, dest_q, dest_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;

  always_comb begin
    mode_d = mode_q;
    log_d  = log_q;
    code_d = code_q;
    dest_d = dest_q;
    tmo_d  = tmo_q;
    if (cfg_we) begin
      mode_d = rx_mode_e'(cfg_mode);
      log_d  = cfg_log_size;
      code_d = cfg_buf_code;
      dest_d = cfg_irq_dest;
      tmo_d  = cfg_timeout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      log_q  <= '0;
      code_q <= '0;
      dest_q <= '0;
      tmo_q  <= '0;
    end else begin
      mode_q <= mode_d;
      log_q  <= log_d;
      code_q <= code_d;
      dest_q <= dest_d;
      tmo_q  <= tmo_d;
    end
  end

  always_comb begin
    if (log_q < LMIN)      log_eff = LMIN;
    else if (log_q > LMAX) log_eff = LMAX;
    else                   log_eff = log_q;
  end

  assign ring_mask = ~({IDX_W{1'b1}} << log_eff);
  assign fill_kb   = ({3'b000, code_q} + 5'd1) << 2;
  assign mode      = mode_q;
  assign irq_dest  = dest_q;
  assign timeout   = tmo_q;

  AST_MASK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ring_mask[LOG_MIN-1:0] == {LOG_MIN{1'b1}}); // R2
endmodule

// File: rtl/rxring_tmr.sv
module rxring_tmr #(
  parameter int TMO_W    = 8,
  parameter int TICK_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_open,
  input  logic             data_in,
  input  logic             close,
  input  logic [TMO_W-1:0] timeout,
  output logic             expire
);
  localparam int PRE_W = $clog2(TICK_CYC + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYC - 1);

  logic             started_q, started_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [TMO_W-1:0] tcnt_q, tcnt_d;
  logic             tick_w;

  assign tick_w = started_q && (pre_q == PRE_LAST);
  assign expire = tick_w && (timeout != '0) && (tcnt_q == timeout - TMO_W'(1));

  always_comb begin
    started_d = started_q;
    pre_d     = pre_q;
    tcnt_d    = tcnt_q;
    if (close) begin
      started_d = 1'b0;
      pre_d     = '0;
      tcnt_d    = '0;
    end else if (!started_q) begin
      if (buf_open && data_in) begin
        started_d = 1'b1;
        pre_d     = '0;
        tcnt_d    = '0;
      end
    end else if (tick_w) begin
      pre_d  = '0;
      tcnt_d = tcnt_q + TMO_W'(1);
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      pre_q     <= '0;
      tcnt_q    <= '0;
    end else begin
      started_q <= started_d;
      pre_q     <= pre_d;
      tcnt_q    <= tcnt_d;
    end
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> pre_q <= PRE_LAST); // R8
  AST_TIMER_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_open |-> !started_q); // R8
endmodule

// File: rtl/rxring_idx.sv
module rxring_idx
  import rxring_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rx_mode_e         mode,
  input  logic [IDX_W-1:0] ring_mask,
  input  logic [1:0]       irq_dest,
  input  logic             cfg_we,
  input  logic             wptr_we,
  input  logic [IDX_W-1:0] wptr_val,
  input  logic             desc_gnt,
  input  logic             frame_end,
  input  logic             buf_done,
  input  logic             expire,
  output logic             desc_req,
  output logic [IDX_W-1:0] desc_idx,
  output logic             buf_open,
  output logic             close,
  output logic             stat_upd,
  output logic [IDX_W-1:0] stat_idx,
  output logic             host_irq,
  output logic             chan_idle
);
  logic [IDX_W-1:0] rd_q, rd_d, wr_q, wr_d, oidx_q, oidx_d, last_q, last_d;
  logic             open_q, open_d, upd_q, upd_d, irq_q, irq_d, stop_q, stop_d;
  logic [IDX_W-1:0] rd_eff, wr_eff;
  logic             room, run_ok, take;

  assign rd_eff   = rd_q & ring_mask;
  assign wr_eff   = wr_q & ring_mask;
  assign room     = (rd_eff != wr_eff);
  assign run_ok   = (mode == MODE_RUN) || ((mode == MODE_EOF) && !stop_q);
  assign desc_req = run_ok && room && !open_q;
  assign take     = desc_req && desc_gnt;
  assign close    = open_q && (buf_done || expire);

  always_comb begin
    rd_d   = take ? ((rd_eff + IDX_W'(1)) & ring_mask) : rd_q;
    wr_d   = wptr_we ? (wptr_val & ~IDX_W'(7)) : wr_q;
    oidx_d = take ? rd_eff : oidx_q;
    last_d = close ? oidx_q : last_q;
    open_d = open_q;
    if (take)       open_d = 1'b1;
    else if (close) open_d = 1'b0;
    upd_d  = close;
    irq_d  = close && (irq_dest == DEST_HOST);
    stop_d = stop_q;
    if (cfg_we)                                 stop_d = 1'b0;
    else if ((mode == MODE_EOF) && frame_end)   stop_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      wr_q   <= '0;
      oidx_q <= '0;
      last_q <= '0;
      open_q <= 1'b0;
      upd_q  <= 1'b0;
      irq_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      oidx_q <= oidx_d;
      last_q <= last_d;
      open_q <= open_d;
      upd_q  <= upd_d;
      irq_q  <= irq_d;
      stop_q <= stop_d;
    end
  end

  assign desc_idx  = rd_eff;
  assign buf_open  = open_q;
  assign stat_upd  = upd_q;
  assign stat_idx  = last_q;
  assign host_irq  = irq_q;
  assign chan_idle = (mode == MODE_OFF) && !open_q;

  AST_WPTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q[2:0] == 3'b000); // R3
  AST_GRANT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (buf_open && !desc_req)); // R5
  AST_CLOSE_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (stat_upd && stat_idx == $past(oidx_q))); // R6
  AST_IRQ_WITH_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> stat_upd); // R7
  AST_SINGLE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_upd |=> !stat_upd); // R9
  AST_IDLE_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    chan_idle |-> !desc_req); // R11
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
#(
  parameter int IDX_W    = 12,
  parameter int LOG_MIN  = 5,
  parameter int LOG_MAX  = 12,
  parameter int TMO_W    = 8,
  parameter int TICK_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [3:0]       cfg_log_size,
  input  logic [1:0]       cfg_buf_code,
  input  logic [1:0]       cfg_irq_dest,
  input  logic [TMO_W-1:0] cfg_timeout,
  input  logic             wptr_we,
  input  logic [IDX_W-1:0] wptr_val,
  output logic             desc_req,
  output logic [IDX_W-1:0] desc_idx,
  input  logic             desc_gnt,
  output logic [4:0]       fill_kb,
  input  logic             data_in,
  input  logic             frame_end,
  input  logic             buf_done,
  output logic             stat_upd,
  output logic [IDX_W-1:0] stat_idx,
  output logic             host_irq,
  output logic             chan_idle
);
  rx_mode_e         mode_w;
  logic [IDX_W-1:0] mask_w;
  logic [1:0]       dest_w;
  logic [TMO_W-1:0] tmo_w;
  logic             open_w, close_w, expire_w;

  rxring_cfg #(.IDX_W(IDX_W), .LOG_MIN(LOG_MIN), .LOG_MAX(LOG_MAX), .TMO_W(TMO_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_log_size(cfg_log_size), .cfg_buf_code(cfg_buf_code),
    .cfg_irq_dest(cfg_irq_dest), .cfg_timeout(cfg_timeout),
    .mode(mode_w), .ring_mask(mask_w), .fill_kb(fill_kb),
    .irq_dest(dest_w), .timeout(tmo_w)
  );

  rxring_tmr #(.TMO_W(TMO_W), .TICK_CYC(TICK_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .buf_open(open_w), .data_in(data_in),
    .close(close_w), .timeout(tmo_w), .expire(expire_w)
  );

  rxring_idx #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .mode(mode_w), .ring_mask(mask_w),
    .irq_dest(dest_w), .cfg_we(cfg_we), .wptr_we(wptr_we), .wptr_val(wptr_val),
    .desc_gnt(desc_gnt), .frame_end(frame_end), .buf_done(buf_done),
    .expire(expire_w), .desc_req(desc_req), .desc_idx(desc_idx),
    .buf_open(open_w), .close(close_w), .stat_upd(stat_upd),
    .stat_idx(stat_idx), .host_irq(host_irq), .chan_idle(chan_idle)
  );
endmodule

// File: tb/rxring_ctrl_tb.sv
module rxring_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_mode, cfg_buf_code, cfg_irq_dest;
  logic [3:0]  cfg_log_size;
  logic [7:0]  cfg_timeout;
  logic        wptr_we;
  logic [11:0] wptr_val;
  logic        desc_req, desc_gnt, data_in, frame_end, buf_done;
  logic [11:0] desc_idx, stat_idx;
  logic [4:0]  fill_kb;
  logic        stat_upd, host_irq, chan_idle;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxring_ctrl #(.TICK_CYC(TICK)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_log_size(cfg_log_size), .cfg_buf_code(cfg_buf_code),
    .cfg_irq_dest(cfg_irq_dest), .cfg_timeout(cfg_timeout),
    .wptr_we(wptr_we), .wptr_val(wptr_val), .desc_req(desc_req),
    .desc_idx(desc_idx), .desc_gnt(desc_gnt), .fill_kb(fill_kb),
    .data_in(data_in), .frame_end(frame_end), .buf_done(buf_done),
    .stat_upd(stat_upd), .stat_idx(stat_idx), .host_irq(host_irq),
    .chan_idle(chan_idle)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 0; cfg_mode = 0; cfg_log_size = 0; cfg_buf_code = 0;
    cfg_irq_dest = 0; cfg_timeout = 0; wptr_we = 0; wptr_val = 0;
    desc_gnt = 0; data_in = 0; frame_end = 0; buf_done = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_cfg(input int mode, input int lg, input int code, input int dest, input int tmo);
    cfg_mode = 2'(mode); cfg_log_size = 4'(lg); cfg_buf_code = 2'(code);
    cfg_irq_dest = 2'(dest); cfg_timeout = 8'(tmo); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_wptr(input int v);
    wptr_val = 12'(v); wptr_we = 1'b1;
    @(negedge clk);
    wptr_we = 1'b0;
  endtask

  task automatic grant(input string req, input int exp_idx);
    check({req, " offer"}, int'(desc_req), 1);
    check({req, " index"}, int'(desc_idx), exp_idx);
    desc_gnt = 1'b1;
    @(negedge clk);
    desc_gnt = 1'b0;
  endtask

  task automatic close_buf(input string req, input int exp_idx, input int exp_irq, input bit eof);
    buf_done = 1'b1; frame_end = eof;
    @(negedge clk);
    buf_done = 1'b0; frame_end = 1'b0;
    check({req, " upd"}, int'(stat_upd), 1);
    check({req, " stat_idx"}, int'(stat_idx), exp_idx);
    check({req, " irq"}, int'(host_irq), exp_irq);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 req", int'(desc_req), 0);
    check("R1 idle", int'(chan_idle), 1);
    check("R1 stat_idx", int'(stat_idx), 0);
    check("R1 upd", int'(stat_upd), 0);
    check("R1 irq", int'(host_irq), 0);
  endtask

  task automatic t_basic();
    do_reset();
    write_cfg(2, 8, 2, 1, 0);
    check("R12 12k", int'(fill_kb), 12);
    check("R4 empty ring", int'(desc_req), 0);
    write_wptr(8);
    for (int i = 0; i < 8; i++) begin
      grant("R5", i);
      check("R5 one open", int'(desc_req), 0);
      @(negedge clk);
      check("R6 no early upd", int'(stat_upd), 0);
      close_buf("R6 R7", i, 1, 1'b0);
    end
    @(negedge clk);
    check("R6 strobe width", int'(stat_upd), 0);
    check("R4 stop at wptr", int'(desc_req), 0);
  endtask

  task automatic t_wrap();
    do_reset();
    write_cfg(2, 3, 3, 0, 0);
    check("R12 16k", int'(fill_kb), 16);
    write_wptr(12'h03B);
    for (int i = 0; i < 24; i++) begin
      grant("R3", i);
      close_buf("R7 none", i, 0, 1'b0);
    end
    check("R3 rounded stop", int'(desc_req), 0);
    write_wptr(0);
    for (int i = 24; i < 32; i++) begin
      grant("R2", i);
      close_buf("R2", i, 0, 1'b0);
    end
    check("R2 full at wrap", int'(desc_req), 0);
    check("R2 wrapped index", int'(desc_idx), 0);
    write_wptr(8);
    grant("R2 after wrap", 0);
  endtask

  task automatic t_tmo();
    int n;
    do_reset();
    write_cfg(2, 8, 0, 1, 3);
    write_wptr(8);
    grant("R8", 0);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (stat_upd) n++;
    end
    check("R8 no data no timer", n, 0);
    data_in = 1'b1;
    @(negedge clk);
    data_in = 1'b0;
    n = 0;
    while (n < 100 && !stat_upd) begin
      @(negedge clk);
      n++;
    end
    check("R8 timeout cycles", n, 3 * TICK);
    check("R8 idx", int'(stat_idx), 0);
    check("R8 irq", int'(host_irq), 1);
    write_cfg(2, 8, 0, 1, 0);
    grant("R8 disabled", 1);
    data_in = 1'b1;
    @(negedge clk);
    data_in = 1'b0;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (stat_upd) n++;
    end
    check("R8 zero disables", n, 0);
    close_buf("R8 done after disabled", 1, 1, 1'b0);
  endtask

  task automatic t_coincide();
    int n;
    do_reset();
    write_cfg(2, 8, 0, 1, 2);
    write_wptr(8);
    grant("R9", 0);
    data_in = 1'b1;
    @(negedge clk);
    data_in = 1'b0;
    n = 0;
    for (int i = 0; i < 2 * TICK - 1; i++) begin
      @(negedge clk);
      if (stat_upd) n++;
    end
    check("R9 not yet", n, 0);
    close_buf("R9 joint", 0, 1, 1'b0);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (stat_upd || host_irq) n++;
    end
    check("R9 single update", n, 0);
    check("R9 one advance", int'(desc_idx), 1);
    check("R9 offer", int'(desc_req), 1);
  endtask

  task automatic t_eof();
    do_reset();
    write_cfg(1, 8, 0, 1, 0);
    write_wptr(16);
    grant("R10", 0);
    close_buf("R10", 0, 1, 1'b0);
    grant("R10 before eof", 1);
    close_buf("R10 eof", 1, 1, 1'b1);
    check("R10 stopped", int'(desc_req), 0);
    write_cfg(2, 8, 0, 1, 0);
    grant("R10 resumed", 2);
    close_buf("R10", 2, 1, 1'b0);
    write_cfg(0, 8, 0, 1, 0);
    check("R10 off", int'(desc_req), 0);
    check("R11 idle off", int'(chan_idle), 1);
  endtask

  task automatic t_idle();
    do_reset();
    write_cfg(2, 8, 0, 0, 0);
    check("R11 run busy", int'(chan_idle), 0);
    write_wptr(8);
    grant("R11", 0);
    write_cfg(0, 8, 0, 0, 0);
    check("R11 open busy", int'(chan_idle), 0);
    close_buf("R11", 0, 0, 1'b0);
    check("R11 idle after close", int'(chan_idle), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_tmo();
    t_coincide();
    t_eof();
    t_idle();
    summary();
  end
endmodule